// File: doc/BRIEF.md
# Interleaved Screen Address Calculator

This block computes addresses for a 256 x 192 monochrome bitmap whose rows are not stored one after another. Memory is cut into three horizontal thirds of 64 rows each. Inside a third, each pixel line of every character row is grouped with the same line of the other character rows. One pixel line is 32 bytes wide and each byte holds eight pixels, with the leftmost pixel in bit 7.

A caller pulses `op_valid` with an operation code and its operands. One clock later the block returns the result with a one-cycle `res_valid` strobe. Three operations are available. The first converts a (row, column) coordinate into the address of the byte that holds that pixel. The second takes a byte address and moves it down by one pixel line, following the interleave rather than a fixed pitch. The third produces the bit mask that selects the pixel within its byte.

Top module: `scr_addr_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `res_valid`, `res_addr` and `res_mask` are all zero.
- R2: Operation code 0 (locate) returns `res_addr` = 0x4000 + (row bits 7:6) * 0x800 + (row bits 2:0) * 0x100 + (row bits 5:3) * 0x20 + (column bits 7:3).
- R3: Locate does not check its row range. Rows 192 to 255 go through the same mapping, which gives addresses 0x5800 and above.
- R4: Operation code 1 (step down): when the pixel line held in `cur_addr` bits 10:8 is below 7, the result is `cur_addr` + 0x100.
- R5: Step down on pixel line 7 of character rows 0 to 6 of a third clears address bits 10:8 and adds 0x20 to the low byte.
- R6: Step down on pixel line 7 of character row 7 of a third moves to line 0 of character row 0 of the next third, keeping the byte column: `cur_addr` + 0x20, for example 0x47E5 gives 0x4805.
- R7: Stepping down from the bottom row is not clamped. 0x57E0 + c gives 0x5800 + c.
- R8: Operation code 2 (mask) returns `res_mask` = 0x80 shifted right by column bits 2:0. Exactly one bit is set, so column 0 gives 0x80 and column 5 gives 0x04.
- R9: `res_valid` is high for exactly one cycle, the cycle after each accepted operation, and is low whenever `op_valid` was low in the cycle before.
- R10: Operation code 3 is ignored. It raises no strobe, and `res_addr` and `res_mask` keep their values.
- R11: Each operation writes only its own output. Mask leaves `res_addr` unchanged, and locate and step down leave `res_mask` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | Operation code: 0 locate, 1 step down, 2 mask, 3 ignored |
| row_i | input | 8 | Pixel row for locate |
| col_i | input | 8 | Pixel column for locate and mask |
| cur_addr | input | 16 | Byte address for step down |
| res_valid | output | 1 | Result strobe, one cycle after the operation |
| res_addr | output | 16 | Registered address result |
| res_mask | output | 8 | Registered pixel mask result |

## Verification
The assertions take it that `op_sel` is known whenever `op_valid` is high. They also take it that `rst` is synchronous, so the reference to the previous cycle's operation code is only made after the reset has been released. The stimulus changes its inputs only on the falling edge and always drives a defined code. The step-down operands are taken from real row addresses in 0x4000 to 0x57FF, so the reference model can decode them back into a row. Out-of-range rows are sent only to the locate operation, where R3 defines what they produce.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    OP_LOCATE = 2'd0,
    OP_STEP   = 2'd1,
    OP_MASK   = 2'd2,
    OP_NONE   = 2'd3
  } scr_op_e;
endpackage

// File: rtl/scr_locate.sv
module scr_locate #(
  parameter int          ADDR_W  = 16,
  parameter int          COORD_W = 8,
  parameter logic [15:0] BASE    = 16'h4000
) (
  input  logic [COORD_W-1:0] row,
  input  logic [COORD_W-1:0] col,
  output logic [ADDR_W-1:0]  addr
);
  localparam int OFS_W = 2 + 3 + 3 + (COORD_W - 3);

  logic [OFS_W-1:0] ofs;

  // third, pixel line, character row, byte column
  always_comb begin
    ofs  = {row[7:6], row[2:0], row[5:3], col[COORD_W-1:3]};
    addr = BASE[ADDR_W-1:0] | {{(ADDR_W-OFS_W){1'b0}}, ofs};
  end
endmodule

// File: rtl/scr_step_down.sv
module scr_step_down #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] nxt
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0] hi_inc;
  logic [8:0]      lo_sum;

  always_comb begin
    hi_inc = cur[ADDR_W-1:8] + 1'b1;
    lo_sum = {1'b0, cur[7:0]} + 9'h020;
    if (hi_inc[2:0] != 3'd0) begin
      nxt = {hi_inc, cur[7:0]};
    end else if (lo_sum[8]) begin
      nxt = {hi_inc, lo_sum[7:0]};
    end else begin
      nxt = {hi_inc - HI_W'(8), lo_sum[7:0]};
    end
  end
endmodule

// File: rtl/scr_bit_mask.sv
module scr_bit_mask #(
  parameter int PIX_PER_BYTE = 8
) (
  input  logic [$clog2(PIX_PER_BYTE)-1:0] pos,
  output logic [PIX_PER_BYTE-1:0]         mask
);
  localparam int POS_W = $clog2(PIX_PER_BYTE);

  for (genvar i = 0; i < PIX_PER_BYTE; i++) begin : g_bit
    assign mask[i] = (pos == POS_W'(PIX_PER_BYTE - 1 - i));
  end
endmodule

// File: rtl/scr_addr_unit.sv
module scr_addr_unit
  import scr_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          COORD_W = 8,
  parameter logic [15:0] BASE    = 16'h4000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic [1:0]         op_sel,
  input  logic [COORD_W-1:0] row_i,
  input  logic [COORD_W-1:0] col_i,
  input  logic [ADDR_W-1:0]  cur_addr,
  output logic               res_valid,
  output logic [ADDR_W-1:0]  res_addr,
  output logic [7:0]         res_mask
);
  localparam int PIX = 8;

  logic [ADDR_W-1:0] loc_addr;
  logic [ADDR_W-1:0] step_addr;
  logic [PIX-1:0]    bit_mask;
  scr_op_e           op;

  assign op = scr_op_e'(op_sel);

  scr_locate #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .BASE(BASE)) u_locate (
    .row  (row_i),
    .col  (col_i),
    .addr (loc_addr)
  );

  scr_step_down #(.ADDR_W(ADDR_W)) u_step (
    .cur (cur_addr),
    .nxt (step_addr)
  );

  scr_bit_mask #(.PIX_PER_BYTE(PIX)) u_mask (
    .pos  (col_i[2:0]),
    .mask (bit_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_mask  <= '0;
    end else begin
      res_valid <= op_valid && (op != OP_NONE);
      if (op_valid) begin
        unique case (op)
          OP_LOCATE: res_addr <= loc_addr;
          OP_STEP:   res_addr <= step_addr;
          OP_MASK:   res_mask <= bit_mask;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scr_addr_unit_chk.sv
module scr_addr_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [1:0]        op_sel,
  input logic              res_valid,
  input logic [ADDR_W-1:0] res_addr,
  input logic [7:0]        res_mask
);
  assert_strobe_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel != 2'd3) |=> res_valid);

  assert_idle_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid);

  assert_reserved_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'd3) |=> (!res_valid && $stable(res_addr) && $stable(res_mask)));

  assert_mask_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'd2) |=> ($countones(res_mask) == 1));

  assert_mask_keeps_addr_R11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'd2) |=> $stable(res_addr));

  assert_addr_ops_keep_mask_R11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel[1] == 1'b0) |=> $stable(res_mask));
endmodule

bind scr_addr_unit scr_addr_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_sel    (op_sel),
  .res_valid (res_valid),
  .res_addr  (res_addr),
  .res_mask  (res_mask)
);

// File: tb/scr_addr_unit_bench.sv
`timescale 1ns/1ps
module scr_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic [7:0]  row_i = 8'd0;
  logic [7:0]  col_i = 8'd0;
  logic [15:0] cur_addr = 16'd0;
  logic        res_valid;
  logic [15:0] res_addr;
  logic [7:0]  res_mask;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  string cur_tag = "R1";
  string exp_tag = "R1";
  bit    exp_valid = 1'b0;
  int    exp_addr  = 0;
  int    exp_mask  = 0;

  always #4 clk = ~clk;

  scr_addr_unit u_scr_addr_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .row_i(row_i), .col_i(col_i), .cur_addr(cur_addr),
    .res_valid(res_valid), .res_addr(res_addr), .res_mask(res_mask)
  );

  // encode a row/column pair arithmetically
  function automatic int encode(int y, int c);
    return 'h4000 + (y / 64) * 2048 + (y % 8) * 256 + ((y / 8) % 8) * 32 + c / 8;
  endfunction

  function automatic int row_of(int a);
    int o = a - 'h4000;
    return ((o >> 11) & 3) * 64 + ((o >> 5) & 7) * 8 + ((o >> 8) & 7);
  endfunction

  // reference model: registered results
  always @(posedge clk) begin
    if (rst) begin
      exp_valid <= 1'b0; exp_addr <= 0; exp_mask <= 0; exp_tag <= "R1";
    end else begin
      exp_valid <= op_valid && op_sel != 2'd3;
      exp_tag   <= op_valid ? cur_tag : "R9";
      if (op_valid) begin
        if (op_sel == 2'd0) exp_addr <= encode(row_i, col_i);
        if (op_sel == 2'd1) exp_addr <= encode(row_of(cur_addr) + 1, (cur_addr & 31) * 8);
        if (op_sel == 2'd2) exp_mask <= 128 / (1 << (col_i % 8));
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (res_valid !== exp_valid) begin
        n_fail++;
        $display("FAIL %s: res_valid actual %0b expected %0b", exp_tag, res_valid, exp_valid);
      end
      n_checks++;
      if (res_addr !== exp_addr[15:0]) begin
        n_fail++;
        $display("FAIL %s: res_addr actual %h expected %h", exp_tag, res_addr, exp_addr[15:0]);
      end
      n_checks++;
      if (res_mask !== exp_mask[7:0]) begin
        n_fail++;
        $display("FAIL %s: res_mask actual %h expected %h", exp_tag, res_mask, exp_mask[7:0]);
      end
    end
  end

  task automatic apply(input bit v, input int op, input int r, input int c,
                       input int a, input string tag);
    @(negedge clk);
    #1;
    op_valid = v; op_sel = 2'(op); row_i = 8'(r); col_i = 8'(c);
    cur_addr = 16'(a); cur_tag = tag;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) apply(0, 0, 0, 0, 0, "R1");
    @(negedge clk); #1; rst = 1'b0;
    apply(0, 0, 0, 0, 0, "R1");
    // R2 locate across valid rows
    for (int y = 0; y < 192; y += 5) apply(1, 0, y, (y * 37) % 256, 0, "R2");
    apply(1, 0, 0, 0, 0, "R2");
    apply(1, 0, 191, 255, 0, "R2");
    // R3 rows out of range
    for (int y = 192; y < 256; y += 9) apply(1, 0, y, y, 0, "R3");
    // R8 and R11 mask, address must hold
    for (int c = 0; c < 16; c++) apply(1, 2, 0, c, 0, "R8");
    apply(1, 2, 0, 5, 0, "R11");
    // R4 R5 R6 R7 step down over every row
    for (int y = 0; y < 192; y++) begin
      int  c = (y * 11) % 256;
      string t;
      if (y == 191) t = "R7";
      else if (y % 8 != 7) t = "R4";
      else if ((y / 8) % 8 != 7) t = "R5";
      else t = "R6";
      apply(1, 1, 0, 0, encode(y, c), t);
    end
    apply(1, 1, 0, 0, 'h57E0, "R7");
    apply(1, 1, 0, 0, 'h47E5, "R6");
    // R11 address ops keep mask
    apply(1, 2, 0, 3, 0, "R11");
    apply(1, 0, 100, 100, 0, "R11");
    apply(1, 1, 0, 0, 'h4100, "R11");
    // R10 reserved code
    apply(1, 3, 50, 7, 'h4000, "R10");
    apply(1, 3, 9, 1, 'h4444, "R10");
    // R9 gaps and back-to-back
    apply(0, 0, 10, 10, 0, "R9");
    apply(1, 0, 10, 10, 0, "R9");
    apply(0, 2, 10, 2, 0, "R9");
    apply(1, 2, 10, 6, 0, "R9");
    apply(1, 1, 0, 0, 'h4020, "R9");
    apply(0, 0, 0, 0, 0, "R9");
    apply(0, 0, 0, 0, 0, "R9");
    finish_run();
  end
endmodule